// File: doc/BRIEF.md
# Time-Slice Coincidence Sorter

The sorter takes one merged stream of detector singles and turns them into coincidence chords. Each single carries a module number, a crystal number and an arrival time counted from the start of the current time slice. A central timing source pulses a boundary strobe at each slice edge. The singles collected between two strobes form one slice.

When a slice closes, its singles are compared with each other one entry per cycle, while the next slice fills the other half of a two-bank buffer. Two singles whose times differ by no more than a programmable window form a candidate. A candidate becomes a chord only if each member has no other neighbour in the window and the two members sit in different modules. The chord word carries both module/crystal identities with the earlier single first, plus the non-negative time difference for time-of-flight use.

The stream has no backpressure. Singles beyond the buffer depth in one slice are dropped and counted.

Top module: `coinc_sorter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `c_valid` is low and `drop_cnt` is zero.
- R2: A single belongs to the slice open when it arrives. A single presented in the same cycle as `slice_end` is the first entry of the new slice, not the last entry of the closing one.
- R3: Two singles can pair only if the absolute difference of their times is less than or equal to `win`. Equality qualifies.
- R4: In a chord word, `c_mod_a`/`c_xtal_a` is the single with the smaller time and `c_mod_b`/`c_xtal_b` is the other one. On equal times the earlier arrival goes first. `c_dt` is the later time minus the earlier time.
- R5: A pair is emitted only if each member has exactly one neighbour within `win`, namely the other member. A group of three or more mutually reachable singles, chains included, yields nothing.
- R6: A pair whose two members carry the same module number is never emitted.
- R7: At most DEPTH singles are kept per slice. Each further single in that slice is discarded and raises `drop_cnt` by one, saturating at its maximum. Discarded singles never take part in pairing.
- R8: Every chord of a slice leaves within 2*DEPTH+2 cycles of the `slice_end` cycle, as one-cycle `c_valid` pulses. `slice_end` pulses must be at least 2*DEPTH+2 cycles apart.
- R9: A slice can yield several chords. They come out in ascending order of the lower arrival index of each pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_end | input | 1 | One-cycle strobe closing the current slice |
| s_valid | input | 1 | Single present this cycle |
| s_mod | input | MOD_W | Module number of the single |
| s_xtal | input | XTAL_W | Crystal number of the single |
| s_ts | input | TS_W | Arrival time within the slice |
| win | input | TS_W | Coincidence window, inclusive |
| c_valid | output | 1 | Chord word valid |
| c_mod_a | output | MOD_W | Module of the earlier single |
| c_xtal_a | output | XTAL_W | Crystal of the earlier single |
| c_mod_b | output | MOD_W | Module of the later single |
| c_xtal_b | output | XTAL_W | Crystal of the later single |
| c_dt | output | TS_W | Later time minus earlier time |
| drop_cnt | output | CNT_W | Saturating count of discarded singles |

## Verification
Each internal fault shows up as a wrong chord count or a wrong chord word within 2*DEPTH+2 cycles of the `slice_end` that closes the affected slice:
- A stale neighbour flag or partner index from the scan pass turns a multiple into a false chord, or suppresses a real one.
- A wrong bank select or write pointer replays singles from an older slice, or loses ones from the boundary cycle.
- An overflow slip is visible at once on `drop_cnt`. It also shows in a slice whose excess singles would otherwise have paired.

// File: rtl/coinc_pkg.sv
`timescale 1ns/1ps
package coinc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_EMIT} srch_st_e;
endpackage

// File: rtl/coinc_slice_buf.sv
`timescale 1ns/1ps
// Two-bank capture store: one bank fills while the other is searched.
module coinc_slice_buf #(
  parameter int MOD_W  = 4,
  parameter int XTAL_W = 8,
  parameter int TS_W   = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slice_end,
  input  logic              in_valid,
  input  logic [MOD_W-1:0]  in_mod,
  input  logic [XTAL_W-1:0] in_xtal,
  input  logic [TS_W-1:0]   in_ts,
  output logic [MOD_W-1:0]  rd_mod  [DEPTH],
  output logic [XTAL_W-1:0] rd_xtal [DEPTH],
  output logic [TS_W-1:0]   rd_ts   [DEPTH],
  output logic [CW-1:0]     rd_cnt,
  output logic [CNT_W-1:0]  drop_cnt
);
  logic              wbank;
  logic [CW-1:0]     wcnt;
  logic [MOD_W-1:0]  mem_mod  [2][DEPTH];
  logic [XTAL_W-1:0] mem_xtal [2][DEPTH];
  logic [TS_W-1:0]   mem_ts   [2][DEPTH];
  logic              room, wsel, wen;
  logic [AW-1:0]     waddr;

  // A single arriving with the strobe opens the new slice.
  always_comb begin
    room  = wcnt < CW'(DEPTH);
    wsel  = slice_end ? ~wbank : wbank;
    waddr = slice_end ? '0 : wcnt[AW-1:0];
    wen   = in_valid && (slice_end || room);
  end

  always_ff @(posedge clk) begin
    if (wen) begin
      mem_mod[wsel][waddr]  <= in_mod;
      mem_xtal[wsel][waddr] <= in_xtal;
      mem_ts[wsel][waddr]   <= in_ts;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank    <= 1'b0;
      wcnt     <= '0;
      rd_cnt   <= '0;
      drop_cnt <= '0;
    end else if (slice_end) begin
      wbank  <= ~wbank;
      rd_cnt <= wcnt;
      wcnt   <= CW'(in_valid);
    end else if (in_valid) begin
      if (room) wcnt <= wcnt + 1'b1;
      else if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      rd_mod[k]  = mem_mod[~wbank][k];
      rd_xtal[k] = mem_xtal[~wbank][k];
      rd_ts[k]   = mem_ts[~wbank][k];
    end
  end
endmodule

// File: rtl/coinc_nbr.sv
`timescale 1ns/1ps
// Neighbour mask: which stored singles lie within the window of entry sel.
module coinc_nbr #(
  parameter int TS_W  = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic [TS_W-1:0]  ts_all [DEPTH],
  input  logic [AW-1:0]    sel,
  input  logic [CW-1:0]    cnt,
  input  logic [TS_W-1:0]  win,
  output logic [DEPTH-1:0] mask
);
  logic [TS_W-1:0] t_sel;
  assign t_sel = ts_all[sel];

  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    logic [TS_W-1:0] gap;
    assign gap = (t_sel >= ts_all[j]) ? t_sel - ts_all[j] : ts_all[j] - t_sel;
    assign mask[j] = (CW'(j) < cnt) && (AW'(j) != sel) && (gap <= win);
  end
endmodule

// File: rtl/coinc_search.sv
`timescale 1ns/1ps
// Serial two-pass search: scan records neighbour data, emit forms chords.
module coinc_search
  import coinc_pkg::*;
#(
  parameter int MOD_W  = 4,
  parameter int XTAL_W = 8,
  parameter int TS_W   = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = 3,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slice_end,
  input  logic [CW-1:0]     cnt,
  input  logic [TS_W-1:0]   win,
  input  logic [MOD_W-1:0]  mod_all  [DEPTH],
  input  logic [XTAL_W-1:0] xtal_all [DEPTH],
  input  logic [TS_W-1:0]   ts_all   [DEPTH],
  output logic              c_valid,
  output logic [MOD_W-1:0]  c_mod_a,
  output logic [XTAL_W-1:0] c_xtal_a,
  output logic [MOD_W-1:0]  c_mod_b,
  output logic [XTAL_W-1:0] c_xtal_b,
  output logic [TS_W-1:0]   c_dt,
  output logic              busy
);
  srch_st_e         st;
  logic             go_q;
  logic [AW-1:0]    idx, first, p, ia, ib;
  logic [CW-1:0]    n_q;
  logic [DEPTH-1:0] one_q, mask;
  logic [AW-1:0]    part_q [DEPTH];
  logic             last, hit;

  coinc_nbr #(.TS_W(TS_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_nbr (
    .ts_all(ts_all), .sel(idx), .cnt(n_q), .win(win), .mask(mask)
  );

  always_comb begin
    first = '0;
    for (int j = DEPTH - 1; j >= 0; j--) if (mask[j]) first = AW'(j);
    last = (CW'(idx) == n_q - CW'(1));
    p    = part_q[idx];
    hit  = one_q[idx] && one_q[p] && (p > idx) && (mod_all[idx] != mod_all[p]);
    ia   = (ts_all[p] < ts_all[idx]) ? p : idx;
    ib   = (ts_all[p] < ts_all[idx]) ? idx : p;
  end

  always_ff @(posedge clk) begin
    if (st == ST_SCAN) begin
      one_q[idx]  <= ($countones(mask) == 1);
      part_q[idx] <= first;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      go_q     <= 1'b0;
      idx      <= '0;
      n_q      <= '0;
      c_valid  <= 1'b0;
      c_mod_a  <= '0;
      c_xtal_a <= '0;
      c_mod_b  <= '0;
      c_xtal_b <= '0;
      c_dt     <= '0;
    end else begin
      go_q    <= slice_end;
      c_valid <= 1'b0;
      case (st)
        ST_IDLE: if (go_q && cnt >= CW'(2)) begin
          st  <= ST_SCAN;
          n_q <= cnt;
          idx <= '0;
        end
        ST_SCAN: begin
          if (last) begin
            st  <= ST_EMIT;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        ST_EMIT: begin
          if (hit) begin
            c_valid  <= 1'b1;
            c_mod_a  <= mod_all[ia];
            c_xtal_a <= xtal_all[ia];
            c_mod_b  <= mod_all[ib];
            c_xtal_b <= xtal_all[ib];
            c_dt     <= ts_all[ib] - ts_all[ia];
          end
          if (last) st <= ST_IDLE;
          else idx <= idx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE) || go_q;
endmodule

// File: rtl/coinc_sorter.sv
`timescale 1ns/1ps
module coinc_sorter #(
  parameter int MOD_W  = 4,
  parameter int XTAL_W = 8,
  parameter int TS_W   = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slice_end,
  input  logic              s_valid,
  input  logic [MOD_W-1:0]  s_mod,
  input  logic [XTAL_W-1:0] s_xtal,
  input  logic [TS_W-1:0]   s_ts,
  input  logic [TS_W-1:0]   win,
  output logic              c_valid,
  output logic [MOD_W-1:0]  c_mod_a,
  output logic [XTAL_W-1:0] c_xtal_a,
  output logic [MOD_W-1:0]  c_mod_b,
  output logic [XTAL_W-1:0] c_xtal_b,
  output logic [TS_W-1:0]   c_dt,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [MOD_W-1:0]  rd_mod  [DEPTH];
  logic [XTAL_W-1:0] rd_xtal [DEPTH];
  logic [TS_W-1:0]   rd_ts   [DEPTH];
  logic [CW-1:0]     rd_cnt;
  logic              busy;

  coinc_slice_buf #(.MOD_W(MOD_W), .XTAL_W(XTAL_W), .TS_W(TS_W),
                    .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .slice_end(slice_end), .in_valid(s_valid),
    .in_mod(s_mod), .in_xtal(s_xtal), .in_ts(s_ts),
    .rd_mod(rd_mod), .rd_xtal(rd_xtal), .rd_ts(rd_ts),
    .rd_cnt(rd_cnt), .drop_cnt(drop_cnt)
  );

  coinc_search #(.MOD_W(MOD_W), .XTAL_W(XTAL_W), .TS_W(TS_W),
                 .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_srch (
    .clk(clk), .rst(rst), .slice_end(slice_end), .cnt(rd_cnt), .win(win),
    .mod_all(rd_mod), .xtal_all(rd_xtal), .ts_all(rd_ts),
    .c_valid(c_valid), .c_mod_a(c_mod_a), .c_xtal_a(c_xtal_a),
    .c_mod_b(c_mod_b), .c_xtal_b(c_xtal_b), .c_dt(c_dt), .busy(busy)
  );
endmodule

// File: rtl/coinc_sorter_chk.sv
`timescale 1ns/1ps
module coinc_sorter_chk #(
  parameter int MOD_W = 4,
  parameter int TS_W  = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             slice_end,
  input logic [TS_W-1:0]  win,
  input logic             c_valid,
  input logic [MOD_W-1:0] c_mod_a,
  input logic [MOD_W-1:0] c_mod_b,
  input logic [TS_W-1:0]  c_dt,
  input logic [CNT_W-1:0] drop_cnt,
  input logic             busy
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!c_valid && drop_cnt == '0));

  // R3: emitted difference never exceeds the window
  a_r3_dt_in_window: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> c_dt <= $past(win));

  // R6: no chord joins a module to itself
  a_r6_modules_differ: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> c_mod_a != c_mod_b);

  // R7: drop counter only holds or steps by one
  a_r7_drop_step: assert property (@(posedge clk) disable iff (rst)
    armed |-> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1));

  // R8: slice strobes spaced beyond the search length
  a_r8_slice_spacing: assert property (@(posedge clk) disable iff (rst)
    slice_end |-> !busy);

  // R8: chords only appear while a search is running
  a_r8_valid_in_search: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> $past(busy));
endmodule

bind coinc_sorter coinc_sorter_chk #(.MOD_W(MOD_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .slice_end(slice_end), .win(win), .c_valid(c_valid),
  .c_mod_a(c_mod_a), .c_mod_b(c_mod_b), .c_dt(c_dt), .drop_cnt(drop_cnt),
  .busy(busy)
);

// File: tb/sim_coinc_sorter.sv
`timescale 1ns/1ps
module sim_coinc_sorter;
  localparam int DEPTH = 8;
  localparam int NV    = 10;

  typedef struct packed {
    logic [7:0]       win;
    logic [2:0]       n;
    logic [3:0][3:0]  m;
    logic [3:0][7:0]  x;
    logic [3:0][7:0]  t;
    logic [1:0]       en;
    logic [3:0]       ema;
    logic [7:0]       exa;
    logic [3:0]       emb;
    logic [7:0]       exb;
    logic [7:0]       edt;
  } vec_t;

  // Singles packed with index 3 leftmost. R3 R4 R5 R6 R9 rows.
  localparam vec_t TBL [NV] = '{
    '{8'd8, 3'd2, {4'd0,4'd0,4'd5,4'd3}, {8'd0,8'd0,8'd40,8'd10}, {8'd0,8'd0,8'd25,8'd20}, 2'd1, 4'd3, 8'd10, 4'd5, 8'd40, 8'd5},
    '{8'd8, 3'd2, {4'd0,4'd0,4'd1,4'd2}, {8'd0,8'd0,8'd9,8'd7},   {8'd0,8'd0,8'd24,8'd30}, 2'd1, 4'd1, 8'd9,  4'd2, 8'd7,  8'd6},
    '{8'd4, 3'd2, {4'd0,4'd0,4'd2,4'd1}, {8'd0,8'd0,8'd2,8'd1},   {8'd0,8'd0,8'd15,8'd10}, 2'd0, 4'd0, 8'd0,  4'd0, 8'd0,  8'd0},
    '{8'd5, 3'd2, {4'd0,4'd0,4'd2,4'd1}, {8'd0,8'd0,8'd2,8'd1},   {8'd0,8'd0,8'd15,8'd10}, 2'd1, 4'd1, 8'd1,  4'd2, 8'd2,  8'd5},
    '{8'd8, 3'd2, {4'd0,4'd0,4'd3,4'd3}, {8'd0,8'd0,8'd2,8'd1},   {8'd0,8'd0,8'd12,8'd10}, 2'd0, 4'd0, 8'd0,  4'd0, 8'd0,  8'd0},
    '{8'd8, 3'd3, {4'd0,4'd3,4'd2,4'd1}, {8'd0,8'd3,8'd2,8'd1},   {8'd0,8'd17,8'd14,8'd10},2'd0, 4'd0, 8'd0,  4'd0, 8'd0,  8'd0},
    '{8'd4, 3'd4, {4'd4,4'd3,4'd2,4'd1}, {8'd4,8'd3,8'd2,8'd1},   {8'd103,8'd100,8'd12,8'd10}, 2'd2, 4'd1, 8'd1, 4'd2, 8'd2, 8'd2},
    '{8'd5, 3'd3, {4'd0,4'd3,4'd2,4'd1}, {8'd0,8'd3,8'd2,8'd1},   {8'd0,8'd18,8'd14,8'd10},2'd0, 4'd0, 8'd0,  4'd0, 8'd0,  8'd0},
    '{8'd0, 3'd2, {4'd0,4'd0,4'd6,4'd4}, {8'd0,8'd0,8'd3,8'd9},   {8'd0,8'd0,8'd50,8'd50}, 2'd1, 4'd4, 8'd9,  4'd6, 8'd3,  8'd0},
    '{8'd8, 3'd1, {4'd0,4'd0,4'd0,4'd7}, {8'd0,8'd0,8'd0,8'd7},   {8'd0,8'd0,8'd0,8'd7},   2'd0, 4'd0, 8'd0,  4'd0, 8'd0,  8'd0}
  };

  logic        clk = 1'b0, rst = 1'b1, slice_end = 1'b0, s_valid = 1'b0;
  logic [3:0]  s_mod = '0;
  logic [7:0]  s_xtal = '0, s_ts = '0, win = '0;
  logic        c_valid;
  logic [3:0]  c_mod_a, c_mod_b;
  logic [7:0]  c_xtal_a, c_xtal_b, c_dt;
  logic [15:0] drop_cnt;

  coinc_sorter u0 (
    .clk(clk), .rst(rst), .slice_end(slice_end), .s_valid(s_valid),
    .s_mod(s_mod), .s_xtal(s_xtal), .s_ts(s_ts), .win(win),
    .c_valid(c_valid), .c_mod_a(c_mod_a), .c_xtal_a(c_xtal_a),
    .c_mod_b(c_mod_b), .c_xtal_b(c_xtal_b), .c_dt(c_dt), .drop_cnt(drop_cnt)
  );

  always #2 clk = ~clk;

  int checks = 0, errs = 0, cyc = 0, got_n = 0, slice_cyc = 0, last_cyc = 0;
  int g_ma [4], g_xa [4], g_mb [4], g_xb [4], g_dt [4];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (c_valid) begin
      if (got_n < 4) begin
        g_ma[got_n] = c_mod_a; g_xa[got_n] = c_xtal_a;
        g_mb[got_n] = c_mod_b; g_xb[got_n] = c_xtal_b; g_dt[got_n] = c_dt;
      end
      got_n = got_n + 1;
      last_cyc = cyc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] m, input logic [7:0] x, input logic [7:0] t);
    @(negedge clk);
    s_valid = 1'b1; s_mod = m; s_xtal = x; s_ts = t;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic close_slice();
    @(negedge clk);
    slice_end = 1'b1; got_n = 0; slice_cyc = cyc;
    @(negedge clk);
    slice_end = 1'b0;
  endtask

  task automatic wait_done();
    repeat (2*DEPTH + 4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 c_valid after reset", c_valid, 0);
    chk("R1 drop_cnt after reset", drop_cnt, 0);

    // Vector table: R3 window, R4 order, R5 multiples, R6 module, R9 multi-pair
    for (int r = 0; r < NV; r++) begin
      win = TBL[r].win;
      for (int k = 0; k < int'(TBL[r].n); k++) put(TBL[r].m[k], TBL[r].x[k], TBL[r].t[k]);
      close_slice();
      wait_done();
      chk($sformatf("R3/R5/R6 row %0d chord count", r), got_n, int'(TBL[r].en));
      if (TBL[r].en > 0) begin
        chk($sformatf("R4 row %0d mod_a", r), g_ma[0], int'(TBL[r].ema));
        chk($sformatf("R4 row %0d xtal_a", r), g_xa[0], int'(TBL[r].exa));
        chk($sformatf("R4 row %0d mod_b", r), g_mb[0], int'(TBL[r].emb));
        chk($sformatf("R4 row %0d xtal_b", r), g_xb[0], int'(TBL[r].exb));
        chk($sformatf("R4 row %0d dt", r), g_dt[0], int'(TBL[r].edt));
        chk($sformatf("R8 row %0d latency ok", r), int'(last_cyc - slice_cyc <= 2*DEPTH + 2), 1);
      end
      if (r == 6) begin
        // R9: second pair follows the first
        chk("R9 second mod_a", g_ma[1], 3);
        chk("R9 second mod_b", g_mb[1], 4);
        chk("R9 second dt", g_dt[1], 3);
      end
    end

    // R7: ten singles, two dropped; the dropped pair must not emerge
    win = 8'd8;
    for (int k = 0; k < 8; k++) put(4'(k + 1), 8'(k), 8'(k * 20));
    put(4'd9, 8'd1, 8'd200);
    put(4'd10, 8'd2, 8'd201);
    close_slice();
    wait_done();
    chk("R7 drop_cnt after overflow", drop_cnt, 2);
    chk("R7 dropped singles not paired", got_n, 0);

    // R2: a single alongside the strobe opens the next slice
    put(4'd1, 8'd1, 8'd10);
    @(negedge clk);
    slice_end = 1'b1; s_valid = 1'b1; s_mod = 4'd2; s_xtal = 8'd2; s_ts = 8'd12;
    got_n = 0; slice_cyc = cyc;
    @(negedge clk);
    slice_end = 1'b0; s_valid = 1'b0;
    wait_done();
    chk("R2 closing slice gets no chord", got_n, 0);
    put(4'd3, 8'd3, 8'd14);
    close_slice();
    wait_done();
    chk("R2 boundary single paired in new slice", got_n, 1);
    chk("R2 boundary mod_a", g_ma[0], 2);
    chk("R2 boundary mod_b", g_mb[0], 3);
    chk("R2 boundary dt", g_dt[0], 2);
    chk("R7 drop_cnt unchanged", drop_cnt, 2);

    summary();
  end
endmodule